// File: doc/BRIEF.md
# Supply and Manual Reset Sequencer

This block turns already-digitized supply health into a clean system reset. It receives three level inputs: a flag that is high while the primary supply is above its trip point, a flag that is high while a secondary rail is above its own trip point, and an active-low push-button input. All three pass through two-flop synchronizers. The reset, driven on a pair of complementary registered outputs, stays asserted while the primary flag is low or the button is pressed. It is released only after both have been good for an unbroken hold-off window.

The hold-off length is picked at run time by a 2-bit select from four cycle counts fixed by parameters. Any bad sample during the window, even a single-cycle glitch, restarts the count from zero. The secondary rail has its own fail flag, which follows the synchronized comparator with no hold-off and never touches the reset path. A system can use that flag as an early power-fail warning, or OR it into its own reset logic.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_i` is high, and afterwards until a release per R2, `sys_rst_o` is 1 and `sys_rst_n_o` is 0. While `rst_i` is high, `sec_fail_o` is 1.
- R2: Counting the first rising edge that samples both `vpri_ok_i` and `man_rst_n_i` high as edge 1, with both still high at every edge, `sys_rst_o` falls after edge N+2, where N is the selected hold-off count. It does not fall earlier.
- R3: A low `vpri_ok_i` sampled at any edge makes `sys_rst_o` 1 after the second edge that follows it (three-edge latency). Reset then stays asserted until a new release per R2.
- R4: A low `man_rst_n_i` asserts reset with the same three-edge latency. After the button is released, reset stays asserted for a complete hold-off per R2.
- R5: `sec_fail_o` after edge k equals the inverse of `vsec_ok_i` sampled at edge k-2. It has no hold-off and no effect on `sys_rst_o`.
- R6: `sys_rst_n_o` is always the complement of `sys_rst_o`.
- R7: `hold_sel_i` encodes the hold-off as 0 → HOLD0, 1 → HOLD1, 2 → HOLD2, 3 → HOLD3 cycles.
- R8: A bad sample on either release input during the hold-off window, even one cycle long, restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vpri_ok_i | input | 1 | Primary supply above trip (asynchronous) |
| vsec_ok_i | input | 1 | Secondary rail above trip (asynchronous) |
| man_rst_n_i | input | 1 | Push-button reset, low while pressed (asynchronous) |
| hold_sel_i | input | 2 | Hold-off select, see R7 |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| sec_fail_o | output | 1 | Secondary rail failed |

## Verification
A hold-off counter that skips or repeats a step moves the reset release by whole cycles, so the release edge is compared against the exact N+2 edge count for every select value. A counter that fails to clear on a glitch shows up as a release that comes too early, in the first window after a one-cycle drop. A synchronizer stage that is stuck or missing shifts the fall of `sec_fail_o` and the assertion of reset off their three-edge latency, and this is visible on the first transition after reset.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    HOLD_A = 2'd0,
    HOLD_B = 2'd1,
    HOLD_C = 2'd2,
    HOLD_D = 2'd3
  } hold_sel_e;

  typedef struct packed {
    logic pri_ok;
    logic sec_ok;
    logic man_n;
  } mon_in_t;

  localparam int MON_W = $bits(mon_in_t);

  // Safe state loaded into the synchronizers: supplies bad, button idle.
  localparam mon_in_t MON_SAFE = '{pri_ok: 1'b0, sec_ok: 1'b0, man_n: 1'b1};

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        st1 <= RST_VAL[b];
        st2 <= RST_VAL[b];
      end else begin
        st1 <= d_i[b];
        st2 <= st1;
      end
    end
    assign q_o[b] = st2;
  end
endmodule

// File: rtl/rsq_holdoff.sv
module rsq_holdoff #(
  parameter int unsigned HOLD0 = 8,
  parameter int unsigned HOLD1 = 20,
  parameter int unsigned HOLD2 = 50,
  parameter int unsigned HOLD3 = 100
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       hold_bad_i,
  input  logic [1:0] sel_i,
  output logic       rst_q_o,
  output logic       rst_n_q_o
);
  import rsq_pkg::*;

  localparam int unsigned HMAX = max_of4(HOLD0, HOLD1, HOLD2, HOLD3);
  localparam int CW = (HMAX < 2) ? 1 : $clog2(HMAX);

  localparam logic [CW-1:0] LIM0 = CW'(HOLD0 - 1);
  localparam logic [CW-1:0] LIM1 = CW'(HOLD1 - 1);
  localparam logic [CW-1:0] LIM2 = CW'(HOLD2 - 1);
  localparam logic [CW-1:0] LIM3 = CW'(HOLD3 - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic          window_done;
  logic          rst_q, rst_n_q;

  always_comb begin
    unique case (hold_sel_e'(sel_i))
      HOLD_A:  last_idx = LIM0;
      HOLD_B:  last_idx = LIM1;
      HOLD_C:  last_idx = LIM2;
      default: last_idx = LIM3;
    endcase
  end

  // ">=" so that lowering the select mid-window never strands the count.
  assign window_done = (cnt_q >= last_idx);

  always_ff @(posedge clk_i) begin
    if (rst_i || hold_bad_i) begin
      cnt_q   <= '0;
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
    end else if (rst_q) begin
      if (window_done) begin
        rst_q   <= 1'b0;
        rst_n_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_q_o   = rst_q;
  assign rst_n_q_o = rst_n_q;
endmodule

// File: rtl/rsq_secmon.sv
module rsq_secmon (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sec_ok_i,
  output logic fail_o
);
  logic fail_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) fail_q <= 1'b1;
    else       fail_q <= ~sec_ok_i;
  end
  assign fail_o = fail_q;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int unsigned HOLD0 = 8,
  parameter int unsigned HOLD1 = 20,
  parameter int unsigned HOLD2 = 50,
  parameter int unsigned HOLD3 = 100
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       vpri_ok_i,
  input  logic       vsec_ok_i,
  input  logic       man_rst_n_i,
  input  logic [1:0] hold_sel_i,
  output logic       sys_rst_o,
  output logic       sys_rst_n_o,
  output logic       sec_fail_o
);
  import rsq_pkg::*;

  mon_in_t raw_in, syn_in;
  logic    hold_bad;

  assign raw_in = '{pri_ok: vpri_ok_i, sec_ok: vsec_ok_i, man_n: man_rst_n_i};

  rsq_sync #(.W(MON_W), .RST_VAL(MON_SAFE)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign hold_bad = ~syn_in.pri_ok | ~syn_in.man_n;

  rsq_holdoff #(.HOLD0(HOLD0), .HOLD1(HOLD1), .HOLD2(HOLD2), .HOLD3(HOLD3)) u_hold (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hold_bad_i (hold_bad),
    .sel_i      (hold_sel_i),
    .rst_q_o    (sys_rst_o),
    .rst_n_q_o  (sys_rst_n_o)
  );

  rsq_secmon u_sec (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .sec_ok_i (syn_in.sec_ok),
    .fail_o   (sec_fail_o)
  );
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk #(
  parameter int unsigned HOLD0 = 8,
  parameter int unsigned HOLD1 = 20,
  parameter int unsigned HOLD2 = 50,
  parameter int unsigned HOLD3 = 100
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       vpri_ok_i,
  input logic       vsec_ok_i,
  input logic       man_rst_n_i,
  input logic [1:0] hold_sel_i,
  input logic       sys_rst_o,
  input logic       sys_rst_n_o,
  input logic       sec_fail_o
);
  localparam int unsigned HMIN0 = (HOLD0 < HOLD1) ? HOLD0 : HOLD1;
  localparam int unsigned HMIN1 = (HOLD2 < HOLD3) ? HOLD2 : HOLD3;
  localparam int unsigned HMIN  = (HMIN0 < HMIN1) ? HMIN0 : HMIN1;

  // Length of the current unbroken run of good release samples.
  logic [15:0] good_run;
  always_ff @(posedge clk_i) begin
    if (rst_i || !vpri_ok_i || !man_rst_n_i) good_run <= '0;
    else if (good_run != 16'hFFFF)          good_run <= good_run + 16'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (sys_rst_o && sec_fail_o));

  assert_outputs_complement_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    sys_rst_n_o == !sys_rst_o);

  assert_primary_drop_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!vpri_ok_i, 3) |-> sys_rst_o);

  assert_button_press_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!man_rst_n_i, 3) |-> sys_rst_o);

  assert_sec_follow_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i, 1) && !$past(rst_i, 2) && !$past(rst_i, 3))
      |-> (sec_fail_o == $past(!vsec_ok_i, 3)));

  assert_holdoff_min_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sys_rst_o) |-> (good_run >= 16'(HMIN)));
endmodule

bind supply_reset_seq supply_reset_seq_chk #(
  .HOLD0(HOLD0), .HOLD1(HOLD1), .HOLD2(HOLD2), .HOLD3(HOLD3)
) u_chk (.*);

// File: tb/sim_supply_reset_seq.sv
module sim_supply_reset_seq;
  localparam int H0 = 6, H1 = 12, H2 = 25, H3 = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, vpri = 1'b0, vsec = 1'b0, mrn = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       o_rst, o_rst_n, o_fail;

  supply_reset_seq #(.HOLD0(H0), .HOLD1(H1), .HOLD2(H2), .HOLD3(H3)) u0 (
    .clk_i(clk), .rst_i(rst), .vpri_ok_i(vpri), .vsec_ok_i(vsec),
    .man_rst_n_i(mrn), .hold_sel_i(sel),
    .sys_rst_o(o_rst), .sys_rst_n_o(o_rst_n), .sec_fail_o(o_fail)
  );

  typedef struct {
    logic  r;
    logic  f;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   run0 = 0, run1 = 0, run2 = 0;
  logic sv0 = 1'b0, sv1 = 1'b0, sv2 = 1'b0;

  function automatic int lim_of(input logic [1:0] s);
    case (s)
      2'd0:    return H0;
      2'd1:    return H1;
      2'd2:    return H2;
      default: return H3;
    endcase
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic r, input logic p, input logic s, input logic m,
                      input string tag);
    exp_t e;
    logic good, sgood;
    @(negedge clk);
    rst = r; vpri = p; vsec = s; mrn = m;
    @(posedge clk);
    #1;
    good  = !r && p && m;
    sgood = !r && s;
    run2 = run1; run1 = run0;
    run0 = good ? run0 + 1 : 0;
    sv2 = sv1; sv1 = sv0; sv0 = sgood;
    e.r   = r ? 1'b1 : !(run2 >= lim_of(sel));
    e.f   = r ? 1'b1 : !sv2;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic repeat_step(input int n, input logic r, input logic p, input logic s,
                             input logic m, input string tag);
    for (int i = 0; i < n; i++) step(r, p, s, m, tag);
  endtask

  // Monitor: compares outputs half a cycle after the edge that produced them.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (o_rst !== e.r) begin
        errors++;
        $display("FAIL %s sys_rst actual=%0b expected=%0b at %0t", e.tag, o_rst, e.r, $time);
      end
      checks++;
      if (o_rst_n !== !e.r) begin
        errors++;
        $display("FAIL R6 sys_rst_n actual=%0b expected=%0b at %0t", o_rst_n, !e.r, $time);
      end
      checks++;
      if (o_fail !== e.f) begin
        errors++;
        $display("FAIL R5 sec_fail actual=%0b expected=%0b at %0t", o_fail, e.f, $time);
      end
    end
  end

  logic finished = 1'b0;

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then primary still low.
    repeat_step(4, 1, 0, 0, 1, "R1");
    repeat_step(10, 0, 0, 1, 1, "R1");
    // R2: primary recovers, release after HOLD0 + 2 edges.
    repeat_step(15, 0, 1, 1, 1, "R2");
    // R3: drop while running, reasserts and recovers.
    repeat_step(2, 0, 0, 1, 1, "R3");
    repeat_step(15, 0, 1, 1, 1, "R3");
    // R8: glitches inside the hold-off window restart the count.
    repeat_step(3, 0, 0, 1, 1, "R8");
    repeat_step(4, 0, 1, 1, 1, "R8");
    repeat_step(1, 0, 0, 1, 1, "R8");
    repeat_step(4, 0, 1, 1, 1, "R8");
    repeat_step(1, 0, 1, 1, 0, "R8");
    repeat_step(15, 0, 1, 1, 1, "R8");
    // R4: button press then full hold-off after release.
    repeat_step(5, 0, 1, 1, 0, "R4");
    repeat_step(15, 0, 1, 1, 1, "R4");
    // R5: secondary toggles leave reset alone.
    repeat_step(5, 0, 1, 0, 1, "R5");
    repeat_step(4, 0, 1, 1, 1, "R5");
    repeat_step(1, 0, 1, 0, 1, "R5");
    repeat_step(6, 0, 1, 1, 1, "R5");
    // R7: every select value, changed only while reset is held.
    for (int s = 1; s < 4; s++) begin
      repeat_step(3, 0, 0, 1, 1, "R7");
      sel = 2'(s);
      repeat_step(lim_of(sel) + 6, 0, 1, 1, 1, "R7");
    end
    sel = 2'd0;
    repeat_step(2, 1, 1, 1, 1, "R1");
    repeat_step(12, 0, 1, 1, 1, "R2");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule